// File: doc/BRIEF.md
# Active-Low Priority Encoder with Chaining Flags

This block reduces a bank of request lines to the binary index of the most urgent one. Every data input, the enable input and every output is active low. A request line is asserted by driving it to 0. When several lines are asserted together, the highest-numbered one wins. The code outputs present the bitwise complement of the winning index.

Two status outputs qualify the code. The any-active flag reports that the block is enabled and at least one line is requesting. The idle flag reports that the block is enabled and no line is requesting. The code for line 0 and the code for "nothing requesting" are the same, so only these two flags tell those cases apart.

The flags also let several encoders form a wider one. The idle flag of the higher-priority stage drives the enable of the lower-priority stage. The any-active flag of the upper stage supplies the extra most-significant code bit. A parameter selects one of two output forms: purely combinational outputs, or outputs registered on the rising clock edge with a synchronous active-high reset.

Top module: `prio_enc_lowtrue`

## Requirements
- R1: A request line is active when it is 0 and inactive when it is 1. With the block enabled and every line at 1, no line is treated as requesting.
- R2: When several lines are 0 together, the highest-numbered one decides the code and every lower line has no effect. Line LINES-1 at 0 gives a code of all zeros, whatever the other lines are.
- R3: The code outputs equal the bitwise complement of the winning line's index. With 8 lines, line 0 gives 111, line 5 gives 010 and line 7 gives 000.
- R4: While the enable input is 1, the code outputs, the any-active flag and the idle flag are all 1, whatever the request lines are.
- R5: While enabled with at least one line at 0, the any-active flag is 0 and the idle flag is 1.
- R6: While enabled with no line at 0, the idle flag is 0, the any-active flag is 1 and the code is all ones, the same code as line 0.
- R7: With REG_OUT=1 (the default), the outputs change one rising clock edge after the inputs they reflect. With REG_OUT=0, they follow the inputs without a clock.
- R8: With REG_OUT=1, a 1 on the reset input at a rising edge drives all outputs to 1 at that edge, whatever the other inputs are.
- R9: Two instances chain into a 2×LINES encoder as follows. The upper stage takes lines LINES..2·LINES-1. Its idle flag drives the lower stage's enable. The combined code is its any-active flag (MSB) followed by the bitwise AND of the two code outputs. The combined code is the complement of the highest active line's index among all 2·LINES lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register; assertions are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the output register |
| en_n | input | 1 | Active-low enable |
| req_n | input | LINES | Active-low request lines; index LINES-1 has the highest priority |
| code_n | output | $clog2(LINES) | Active-low code of the winning line |
| any_n | output | 1 | Low when enabled and some line is requesting |
| idle_n | output | 1 | Low when enabled and no line is requesting |

## Verification
The assertions check four things on every cycle, each against the inputs of the previous cycle in registered mode. The two flags must be at opposite levels while the block is enabled. All outputs must be inactive while it is disabled. The all-idle code must be ones. The top line must force an all-zero code. The reset rule is also checked. The bench covers what the assertions cannot. It runs one active line at each position, mixes in random lower-priority noise, and checks that reset overrides live inputs in mid-stream. It also builds a two-stage chain and checks the combined 16-line code across both halves, including the handover at the stage boundary.

// File: rtl/pe_pkg.sv
package pe_pkg;
  typedef enum logic {
    OUT_COMB = 1'b0,
    OUT_REG  = 1'b1
  } out_mode_e;

  typedef struct packed {
    logic any_n;
    logic idle_n;
  } flags_t;

  localparam flags_t FLAGS_OFF = '{any_n: 1'b1, idle_n: 1'b1};
endpackage

// File: rtl/pe_scan.sv
module pe_scan #(
  parameter int LINES = 8,
  localparam int CW = $clog2(LINES)
) (
  input  logic [LINES-1:0] req_n,
  output logic [CW-1:0]    win_idx,
  output logic             hit
);
  always_comb begin
    win_idx = '0;
    hit     = 1'b0;
    for (int i = 0; i < LINES; i++) begin
      if (!req_n[i]) begin
        win_idx = CW'(i);
        hit     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pe_flags.sv
module pe_flags #(
  parameter int LINES = 8,
  localparam int CW = $clog2(LINES)
) (
  input  logic           en_n,
  input  logic [CW-1:0]  win_idx,
  input  logic           hit,
  output logic [CW-1:0]  code_n,
  output pe_pkg::flags_t flags
);
  always_comb begin
    if (en_n) begin
      code_n = '1;
      flags  = pe_pkg::FLAGS_OFF;
    end else begin
      code_n       = ~win_idx;
      flags.any_n  = ~hit;
      flags.idle_n = hit;
    end
  end
endmodule

// File: rtl/pe_stage.sv
module pe_stage #(
  parameter int LINES = 8,
  parameter pe_pkg::out_mode_e MODE = pe_pkg::OUT_REG,
  localparam int CW = $clog2(LINES)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [CW-1:0]  code_d,
  input  pe_pkg::flags_t flags_d,
  output logic [CW-1:0]  code_q,
  output pe_pkg::flags_t flags_q
);
  generate
    if (MODE == pe_pkg::OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          code_q  <= '1;
          flags_q <= pe_pkg::FLAGS_OFF;
        end else begin
          code_q  <= code_d;
          flags_q <= flags_d;
        end
      end
      a_r8_reset_inactive: assert property (@(posedge clk)
        rst |=> (code_q == '1 && flags_q == pe_pkg::FLAGS_OFF));
    end else begin : g_comb
      assign code_q  = code_d;
      assign flags_q = flags_d;
    end
  endgenerate
endmodule

// File: rtl/prio_enc_lowtrue.sv
module prio_enc_lowtrue #(
  parameter int LINES = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int CW = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_n,
  input  logic [LINES-1:0] req_n,
  output logic [CW-1:0]    code_n,
  output logic             any_n,
  output logic             idle_n
);
  localparam pe_pkg::out_mode_e MODE = REG_OUT ? pe_pkg::OUT_REG : pe_pkg::OUT_COMB;

  logic [CW-1:0]  win_idx;
  logic           hit;
  logic [CW-1:0]  code_d;
  logic [CW-1:0]  code_q;
  pe_pkg::flags_t flags_d;
  pe_pkg::flags_t flags_q;

  pe_scan #(.LINES(LINES)) u_scan (
    .req_n(req_n), .win_idx(win_idx), .hit(hit)
  );

  pe_flags #(.LINES(LINES)) u_flags (
    .en_n(en_n), .win_idx(win_idx), .hit(hit),
    .code_n(code_d), .flags(flags_d)
  );

  pe_stage #(.LINES(LINES), .MODE(MODE)) u_stage (
    .clk(clk), .rst(rst), .code_d(code_d), .flags_d(flags_d),
    .code_q(code_q), .flags_q(flags_q)
  );

  assign code_n = code_q;
  assign any_n  = flags_q.any_n;
  assign idle_n = flags_q.idle_n;

  generate
    if (REG_OUT) begin : g_chk_reg
      a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        en_n |=> (code_n == '1 && any_n && idle_n));
      a_r5_flags_opposite: assert property (@(posedge clk) disable iff (rst)
        !en_n |=> (any_n != idle_n));
      a_r6_idle_code_ones: assert property (@(posedge clk) disable iff (rst)
        (!en_n && &req_n) |=> (!idle_n && any_n && code_n == '1));
      a_r2_top_line_wins: assert property (@(posedge clk) disable iff (rst)
        (!en_n && !req_n[LINES-1]) |=> (code_n == '0 && !any_n));
    end else begin : g_chk_comb
      a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        en_n |-> (code_n == '1 && any_n && idle_n));
      a_r5_flags_opposite: assert property (@(posedge clk) disable iff (rst)
        !en_n |-> (any_n != idle_n));
      a_r6_idle_code_ones: assert property (@(posedge clk) disable iff (rst)
        (!en_n && &req_n) |-> (!idle_n && any_n && code_n == '1));
      a_r2_top_line_wins: assert property (@(posedge clk) disable iff (rst)
        (!en_n && !req_n[LINES-1]) |-> (code_n == '0 && !any_n));
    end
  endgenerate
endmodule

// File: tb/sim_prio_enc_lowtrue.sv
module sim_prio_enc_lowtrue;
  localparam int LINES = 8;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_n = 1'b1;
  logic [LINES-1:0] req_n = '1;
  logic [CW-1:0] code_n;
  logic any_n, idle_n;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  prio_enc_lowtrue #(.LINES(LINES), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst(rst), .en_n(en_n), .req_n(req_n),
    .code_n(code_n), .any_n(any_n), .idle_n(idle_n)
  );

  // cascade: two combinational stages form a 16-line encoder
  logic [2*LINES-1:0] wide_n = '1;
  logic wide_en_n = 1'b0;
  logic [CW-1:0] hi_code, lo_code;
  logic hi_any, hi_idle, lo_any, lo_idle;

  prio_enc_lowtrue #(.LINES(LINES), .REG_OUT(1'b0)) u_hi (
    .clk(clk), .rst(1'b0), .en_n(wide_en_n), .req_n(wide_n[2*LINES-1:LINES]),
    .code_n(hi_code), .any_n(hi_any), .idle_n(hi_idle)
  );
  prio_enc_lowtrue #(.LINES(LINES), .REG_OUT(1'b0)) u_lo (
    .clk(clk), .rst(1'b0), .en_n(hi_idle), .req_n(wide_n[LINES-1:0]),
    .code_n(lo_code), .any_n(lo_any), .idle_n(lo_idle)
  );

  typedef struct packed {
    logic [CW-1:0] code;
    logic any;
    logic idle;
    logic [7:0] tag;
  } exp_t;

  exp_t sb[$];

  function automatic exp_t model(input logic r, input logic e, input logic [LINES-1:0] q, input logic [7:0] tag);
    exp_t x;
    x.tag = tag;
    x.code = '1; x.any = 1'b1; x.idle = 1'b1;
    if (!r && !e) begin
      x.idle = 1'b0;
      for (int i = LINES - 1; i >= 0; i--) begin
        if (!q[i] && x.any) begin
          x.code = ~CW'(i);
          x.any = 1'b0;
          x.idle = 1'b1;
        end
      end
    end
    return x;
  endfunction

  task automatic drive(input logic r, input logic e, input logic [LINES-1:0] q, input logic [7:0] tag);
    @(negedge clk);
    rst = r; en_n = e; req_n = q;
    sb.push_back(model(r, e, q, tag));
  endtask

  // monitor: one expected item per rising edge, sampled 1 ns later
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t x;
      x = sb.pop_front();
      n_chk++;
      if (code_n !== x.code || any_n !== x.any || idle_n !== x.idle) begin
        n_fail++;
        $display("FAIL R%0s: got code=%b any=%b idle=%b exp code=%b any=%b idle=%b",
                 string'(x.tag), code_n, any_n, idle_n, x.code, x.any, x.idle);
      end
    end
  end

  task automatic wide_check(input logic [2*LINES-1:0] q);
    logic [CW:0] got, exp;
    logic ex_any;
    wide_n = q;
    #1;
    got = {hi_any, hi_code & lo_code};
    exp = '1; ex_any = 1'b1;
    for (int i = 2*LINES - 1; i >= 0; i--) begin
      if (!q[i] && ex_any) begin exp = ~(CW+1)'(i); ex_any = 1'b0; end
    end
    n_chk++;
    if (got !== exp || (hi_any & lo_any) !== ex_any) begin
      n_fail++;
      $display("FAIL R9: req=%b got code=%b any=%b exp code=%b any=%b",
               q, got, hi_any & lo_any, exp, ex_any);
    end
  endtask

  initial begin
    // R8 / reset state
    drive(1'b1, 1'b0, 8'h00, "8");
    drive(1'b1, 1'b0, 8'h7F, "8");
    // R4: disabled, various requests
    drive(1'b0, 1'b1, 8'h00, "4");
    drive(1'b0, 1'b1, 8'h5A, "4");
    // R6 / R1: enabled, nothing requesting
    drive(1'b0, 1'b0, 8'hFF, "6");
    // R3 / R5: one line at each position
    for (int i = 0; i < LINES; i++) drive(1'b0, 1'b0, ~(8'h01 << i), "3");
    // R2: highest line wins with lower noise
    for (int i = 0; i < LINES; i++) begin
      logic [LINES-1:0] q;
      q = ~(8'h01 << i);
      q = q & ~(8'($urandom) & ((8'h01 << i) - 8'h01));
      drive(1'b0, 1'b0, q, "2");
    end
    drive(1'b0, 1'b0, 8'h00, "2");
    // R7: back-to-back changes, one-edge latency
    drive(1'b0, 1'b0, 8'hFE, "7");
    drive(1'b0, 1'b0, 8'hEF, "7");
    drive(1'b0, 1'b1, 8'hEF, "7");
    drive(1'b0, 1'b0, 8'hFF, "7");
    // R8: reset overrides live inputs mid-stream
    drive(1'b1, 1'b0, 8'h3C, "8");
    drive(1'b0, 1'b0, 8'h3C, "5");
    for (int k = 0; k < 40; k++) drive(1'b0, 1'($urandom % 5 == 0), 8'($urandom), "5");
    drive(1'b0, 1'b1, 8'hFF, "4");
    @(negedge clk); @(negedge clk);
    // R9: cascade
    wide_check(16'hFFFF);
    wide_check(16'hFFFE);
    wide_check(16'hFF7F);
    wide_check(16'hFEFF);
    wide_check(16'h7FFF);
    wide_check(16'hFE00);
    wide_check(16'hEF3B);
    for (int k = 0; k < 20; k++) wide_check(16'($urandom) | 16'($urandom));
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule